// File: doc/BRIEF.md
# I2C Interrupt Request Controller

This block turns the status events of an I2C controller into four interrupt requests for a system interrupt controller. The first is a combined error/event request that covers lost arbitration, a missing acknowledge, a bus timeout, a detected start condition and a detected stop condition. The other three are receive-buffer-full, transmit-buffer-empty and transmit-finished. The block holds one sticky status flag per source. It clears those flags when the matching data register is accessed, when a stop is seen, or when software asks for it. Each request is the AND of a flag and its enable bit.

The receive and transmit-empty requests are edge-triggered and are the two that a DMA engine may consume. Each one pulses for a single cycle when its flag-and-enable term goes high. If the interrupt controller's pending bit for that source is still set when the edge occurs, the pulse is not emitted. It is kept in a one-entry slot and released on the first cycle the pending bit is seen low. Clearing the source's enable bit empties the slot. The error/event and transmit-finished requests are plain level outputs.

Top module: `i2c_irq_ctrl`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, every flag, every held request and every request output is cleared to 0.
- R2: A one on bit i of `ev_src` sets `flag_src[i]`. The flag stays set until a one on `sw_clr_src[i]` clears it. When the set and the clear arrive in the same cycle, the flag ends up set. Bit positions are: 0 arbitration lost, 1 NACK, 2 timeout, 3 start detected, 4 stop detected.
- R3: `irq_evt` is high, with no register delay, exactly when at least one bit position has both `flag_src` and `en_src` set.
- R4: `ev_rx_full` sets `flag_rx`, and `rd_rxdata` clears it. The set wins when both occur in the same cycle.
- R5: `ev_tx_empty` sets `flag_tx`. A `wr_txdata` strobe or a stop event (`ev_src[4]`) clears it. The set wins when both occur in the same cycle.
- R6: `ev_tx_end` sets `flag_tend`. A `wr_txdata` strobe, a stop event or `sw_clr_tend` clears it. `irq_tend` is high, with no register delay, exactly when `flag_tend` and `en_tend` are both high.
- R7: With the pending bit low, `irq_rx` / `irq_tx` goes high for exactly one cycle, on the cycle after the flag-and-enable term first becomes true. No further pulse follows while that term stays true.
- R8: If the pending bit (`ir_rx` / `ir_tx`) is high when such an edge is detected, no pulse is emitted while it stays high. A single pulse follows the first clock edge at which it is sampled low, no matter how many edges occurred in the meantime.
- R9: Sampling the source's enable bit low discards a held request, so no pulse appears later for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_src | input | N_EVT | Set strobes for the error/event flags |
| ev_rx_full | input | 1 | Receive buffer became full |
| ev_tx_empty | input | 1 | Transmit buffer became empty |
| ev_tx_end | input | 1 | Transmission finished |
| wr_txdata | input | 1 | Transmit data register written |
| rd_rxdata | input | 1 | Receive data register read |
| sw_clr_src | input | N_EVT | Software clear for the error/event flags |
| sw_clr_tend | input | 1 | Software clear for the transmit-finished flag |
| en_src | input | N_EVT | Enables for the error/event sources |
| en_rx | input | 1 | Receive request enable |
| en_tx | input | 1 | Transmit-empty request enable |
| en_tend | input | 1 | Transmit-finished request enable |
| ir_rx | input | 1 | Interrupt controller pending bit, receive source |
| ir_tx | input | 1 | Interrupt controller pending bit, transmit-empty source |
| irq_evt | output | 1 | Combined error/event request (level) |
| irq_rx | output | 1 | Receive-full request (pulse) |
| irq_tx | output | 1 | Transmit-empty request (pulse) |
| irq_tend | output | 1 | Transmit-finished request (level) |
| flag_src | output | N_EVT | Error/event status flags |
| flag_rx | output | 1 | Receive-full flag |
| flag_tx | output | 1 | Transmit-empty flag |
| flag_tend | output | 1 | Transmit-finished flag |

## Verification
The hardest state to reach is the hold slot. It is occupied only while the pending bit is high, and it can be emptied without any visible output. The bench holds the pending bit high through a receive edge. It then clears and re-sets the flag to create a second edge, and shows that lowering the pending bit yields exactly one pulse. For the discard case, the bench occupies the slot, drops the enable, clears the flag and re-enables with the pending bit low. This order makes sure a surviving held request is the only thing that could produce a pulse.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int EVT_KINDS = 5;
   localparam int EV_ARB    = 0;
   localparam int EV_NACK   = 1;
   localparam int EV_TMO    = 2;
   localparam int EV_START  = 3;
   localparam int EV_STOP   = 4;
   localparam int N_EDGE    = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);
   if (W < 1) begin : g_bad_w
      $error("irq_flag_bank: W must be at least 1");
   end

   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= set_i | (q & ~clr_i);
   end

   assign flag_o = q;

   // R2 / R4 / R5: a set strobe always leaves the flag high
   a_r2_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
   // R2: a clear without a set leaves the flag low
   a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~set_i)) |=> ((q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/irq_edge_gate.sv
module irq_edge_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic flag_i,
   input  logic en_i,
   input  logic pend_i,
   output logic req_o
);
   logic cond, cond_q, rise, held_q, req_q;

   assign cond = flag_i & en_i;
   assign rise = cond & ~cond_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cond_q <= 1'b0;
         held_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         cond_q <= cond;
         if (!en_i) begin
            held_q <= 1'b0;
            req_q  <= 1'b0;
         end else if (rise || held_q) begin
            if (pend_i) begin
               held_q <= 1'b1;
               req_q  <= 1'b0;
            end else begin
               held_q <= 1'b0;
               req_q  <= 1'b1;
            end
         end else begin
            req_q <= 1'b0;
         end
      end
   end

   assign req_o = req_q;

   // R8: nothing leaves while the controller still has the source pending
   a_r8_quiet_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pend_i |=> !req_o);
   // R8: the slot keeps its request while pending and enabled
   a_r8_slot_retained: assert property (@(posedge clk) disable iff (!rst_n)
      (held_q && pend_i && en_i) |=> held_q);
   // R9: a disabled source neither pulses nor keeps a held request
   a_r9_disable_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!req_o && !held_q));
   // R7: no pulse without a fresh edge or a held request
   a_r7_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (!cond && !held_q) |=> !req_o);
endmodule

// File: rtl/i2c_irq_ctrl.sv
module i2c_irq_ctrl
   import i2c_irq_pkg::*;
#(
   parameter int N_EVT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] ev_src,
   input  logic             ev_rx_full,
   input  logic             ev_tx_empty,
   input  logic             ev_tx_end,
   input  logic             wr_txdata,
   input  logic             rd_rxdata,
   input  logic [N_EVT-1:0] sw_clr_src,
   input  logic             sw_clr_tend,
   input  logic [N_EVT-1:0] en_src,
   input  logic             en_rx,
   input  logic             en_tx,
   input  logic             en_tend,
   input  logic             ir_rx,
   input  logic             ir_tx,
   output logic             irq_evt,
   output logic             irq_rx,
   output logic             irq_tx,
   output logic             irq_tend,
   output logic [N_EVT-1:0] flag_src,
   output logic             flag_rx,
   output logic             flag_tx,
   output logic             flag_tend
);
   if (N_EVT != EVT_KINDS) begin : g_bad_nevt
      $error("i2c_irq_ctrl: N_EVT must equal the number of event kinds");
   end

   localparam int NF     = N_EVT + 3;
   localparam int IDX_RX = N_EVT;
   localparam int IDX_TX = N_EVT + 1;
   localparam int IDX_TE = N_EVT + 2;

   logic          stop_ev;
   logic [NF-1:0] f_set, f_clr, fq;

   assign stop_ev = ev_src[EV_STOP];
   assign f_set   = {ev_tx_end, ev_tx_empty, ev_rx_full, ev_src};
   assign f_clr   = {wr_txdata | stop_ev | sw_clr_tend,
                     wr_txdata | stop_ev,
                     rd_rxdata,
                     sw_clr_src};

   irq_flag_bank #(.W(NF)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set),
      .clr_i  (f_clr),
      .flag_o (fq)
   );

   logic [N_EDGE-1:0] e_flag, e_en, e_pend, e_req;
   assign e_flag = {fq[IDX_TX], fq[IDX_RX]};
   assign e_en   = {en_tx, en_rx};
   assign e_pend = {ir_tx, ir_rx};

   for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
      irq_edge_gate u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .flag_i (e_flag[g]),
         .en_i   (e_en[g]),
         .pend_i (e_pend[g]),
         .req_o  (e_req[g])
      );
   end

   assign flag_src  = fq[N_EVT-1:0];
   assign flag_rx   = fq[IDX_RX];
   assign flag_tx   = fq[IDX_TX];
   assign flag_tend = fq[IDX_TE];
   assign irq_rx    = e_req[0];
   assign irq_tx    = e_req[1];
   assign irq_evt   = |(fq[N_EVT-1:0] & en_src);
   assign irq_tend  = fq[IDX_TE] & en_tend;

   // R5 / R6: a stop event with no new set empties both transmit flags
   a_r6_stop_drops_tx: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_ev && !ev_tx_empty && !ev_tx_end) |=> (!flag_tx && !flag_tend));
   // R1: outputs are quiet right after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!irq_rx && !irq_tx && !flag_tend && flag_src == '0));
endmodule

// File: tb/sim_i2c_irq_ctrl.sv
module sim_i2c_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [4:0] ev_src, sw_clr_src, en_src, flag_src;
   logic ev_rx_full, ev_tx_empty, ev_tx_end, wr_txdata, rd_rxdata, sw_clr_tend;
   logic en_rx, en_tx, en_tend, ir_rx, ir_tx;
   logic irq_evt, irq_rx, irq_tx, irq_tend, flag_rx, flag_tx, flag_tend;
   int   n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   i2c_irq_ctrl #(.N_EVT(5)) u0 (
      .clk(clk), .rst_n(rst_n), .ev_src(ev_src), .ev_rx_full(ev_rx_full),
      .ev_tx_empty(ev_tx_empty), .ev_tx_end(ev_tx_end), .wr_txdata(wr_txdata),
      .rd_rxdata(rd_rxdata), .sw_clr_src(sw_clr_src), .sw_clr_tend(sw_clr_tend),
      .en_src(en_src), .en_rx(en_rx), .en_tx(en_tx), .en_tend(en_tend),
      .ir_rx(ir_rx), .ir_tx(ir_tx), .irq_evt(irq_evt), .irq_rx(irq_rx),
      .irq_tx(irq_tx), .irq_tend(irq_tend), .flag_src(flag_src),
      .flag_rx(flag_rx), .flag_tx(flag_tx), .flag_tend(flag_tend));

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ev_src = '0; sw_clr_src = '0; en_src = '0;
      ev_rx_full = 0; ev_tx_empty = 0; ev_tx_end = 0;
      wr_txdata = 0; rd_rxdata = 0; sw_clr_tend = 0;
      en_rx = 0; en_tx = 0; en_tend = 0; ir_rx = 0; ir_tx = 0;
   endtask

   task automatic quiesce();
      idle_inputs();
      sw_clr_src = '1; sw_clr_tend = 1; rd_rxdata = 1; wr_txdata = 1;
      tick();
      idle_inputs();
      tick();
   endtask

   task automatic t_reset();
      idle_inputs();
      rst_n = 0;
      tick(); tick();
      chk("R1 flags after reset", {flag_src, flag_rx, flag_tx, flag_tend}, 0);
      chk("R1 irqs after reset", {irq_evt, irq_rx, irq_tx, irq_tend}, 0);
      rst_n = 1;
      // set flags and hold a request, then reset again
      en_rx = 1; ir_rx = 1; ev_rx_full = 1; ev_src = 5'h1F; ev_tx_end = 1; ev_tx_empty = 1;
      tick();
      ev_rx_full = 0; ev_src = 0; ev_tx_end = 0; ev_tx_empty = 0;
      tick();
      rst_n = 0;
      tick();
      rst_n = 1; ir_rx = 0;
      chk("R1 flags after mid-run reset", {flag_src, flag_rx, flag_tx, flag_tend}, 0);
      tick(); tick();
      chk("R1 held request dropped by reset", irq_rx, 0);
      quiesce();
   endtask

   task automatic t_evt();
      for (int i = 0; i < 5; i++) begin
         ev_src = 5'(1 << i);
         tick();
         ev_src = 0;
         chk($sformatf("R2 flag_src bit %0d set", i), flag_src, 32'(1 << i));
         chk("R3 irq_evt low with source disabled", irq_evt, 0);
         en_src = ~5'(1 << i);
         #1 chk("R3 other enables do not raise irq_evt", irq_evt, 0);
         en_src = 5'(1 << i);
         #1 chk("R3 matching enable raises irq_evt", irq_evt, 1);
         sw_clr_src = 5'(1 << i);
         tick();
         sw_clr_src = 0;
         chk("R2 software clear", flag_src, 0);
         chk("R3 irq_evt follows clear", irq_evt, 0);
         en_src = 0;
      end
      ev_src = 5'h04; sw_clr_src = 5'h04;
      tick();
      ev_src = 0; sw_clr_src = 0;
      chk("R2 set wins over same-cycle clear", flag_src, 32'h04);
      quiesce();
   endtask

   task automatic t_rx();
      en_rx = 1;
      ev_rx_full = 1; tick(); ev_rx_full = 0;
      chk("R4 flag_rx set", flag_rx, 1);
      chk("R7 no pulse in flag cycle", irq_rx, 0);
      tick(); chk("R7 pulse one cycle after flag", irq_rx, 1);
      tick(); chk("R7 pulse lasts one cycle", irq_rx, 0);
      tick(); chk("R7 no repeat while term high", irq_rx, 0);
      ev_rx_full = 1; rd_rxdata = 1; tick(); ev_rx_full = 0; rd_rxdata = 0;
      chk("R4 set wins over read", flag_rx, 1);
      rd_rxdata = 1; tick(); rd_rxdata = 0;
      chk("R4 read clears flag_rx", flag_rx, 0);
      quiesce();
   endtask

   task automatic t_tx();
      en_tx = 1;
      ev_tx_empty = 1; tick(); ev_tx_empty = 0;
      chk("R5 flag_tx set", flag_tx, 1);
      tick(); chk("R7 tx pulse", irq_tx, 1);
      tick(); chk("R7 tx pulse single", irq_tx, 0);
      wr_txdata = 1; tick(); wr_txdata = 0;
      chk("R5 write clears flag_tx", flag_tx, 0);
      ev_tx_empty = 1; tick(); ev_tx_empty = 0;
      tick(); chk("R7 tx pulse after new edge", irq_tx, 1);
      ev_src = 5'h10; tick(); ev_src = 0;
      chk("R5 stop event clears flag_tx", flag_tx, 0);
      chk("R2 stop flag set", flag_src, 32'h10);
      ev_tx_empty = 1; wr_txdata = 1; tick(); ev_tx_empty = 0; wr_txdata = 0;
      chk("R5 set wins over write", flag_tx, 1);
      quiesce();
   endtask

   task automatic t_tend();
      ev_tx_end = 1; tick(); ev_tx_end = 0;
      chk("R6 flag_tend set", flag_tend, 1);
      chk("R6 irq_tend low when disabled", irq_tend, 0);
      en_tend = 1;
      #1 chk("R6 irq_tend follows enable", irq_tend, 1);
      sw_clr_tend = 1; tick(); sw_clr_tend = 0;
      chk("R6 software clear", {flag_tend, irq_tend}, 0);
      ev_tx_end = 1; tick(); ev_tx_end = 0;
      ev_src = 5'h10; tick(); ev_src = 0;
      chk("R6 stop clears flag_tend", flag_tend, 0);
      ev_tx_end = 1; tick(); ev_tx_end = 0;
      wr_txdata = 1; tick(); wr_txdata = 0;
      chk("R6 write clears flag_tend", flag_tend, 0);
      quiesce();
   endtask

   task automatic t_hold();
      en_rx = 1; ir_rx = 1;
      ev_rx_full = 1; tick(); ev_rx_full = 0;
      tick(); chk("R8 no pulse while pending", irq_rx, 0);
      tick(); tick();
      chk("R8 still held", irq_rx, 0);
      rd_rxdata = 1; tick(); rd_rxdata = 0;
      ev_rx_full = 1; tick(); ev_rx_full = 0;
      tick(); chk("R8 second edge also held", irq_rx, 0);
      ir_rx = 0;
      tick(); chk("R8 release pulse", irq_rx, 1);
      tick(); chk("R8 only one pulse released", irq_rx, 0);
      tick(); chk("R8 no extra pulse", irq_rx, 0);
      quiesce();
   endtask

   task automatic t_discard();
      en_rx = 1; ir_rx = 1;
      ev_rx_full = 1; tick(); ev_rx_full = 0;
      tick();
      en_rx = 0; tick();
      rd_rxdata = 1; tick(); rd_rxdata = 0;
      en_rx = 1; ir_rx = 0;
      for (int k = 0; k < 3; k++) begin
         tick(); chk("R9 discarded request stays silent", irq_rx, 0);
      end
      chk("R9 flag_rx clear", flag_rx, 0);
      ev_rx_full = 1; tick(); ev_rx_full = 0;
      tick(); chk("R9 source still works after flush", irq_rx, 1);
      quiesce();
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_evt();
      t_rx();
      t_tx();
      t_tend();
      t_hold();
      t_discard();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule